// File: doc/BRIEF.md
# Pixel Output Channel Formatter

This block sits on the pixel clock, between the pixel pipeline and a parallel display port. It takes one 24-bit pixel per valid cycle, made of three 8-bit components, and returns three output lanes one cycle later. Along the way it can swap red and blue, permute the three channels, and widen each component to 12 bits. Each widened component is clamped to a programmable range, with one range for luma and another for chroma. The components are then arranged in one of several luma/chroma lane layouts, and each lane is scaled to the selected output bit depth.

Colour-space conversion is not done here. When 4:2:2 output is wanted, the upstream pipeline already supplies Y, Cb and Cr in the three input positions. The block then raises its conversion-active flag and forces the channel order to identity. All configuration inputs are static; they may change between frames.

Top module: `pfmt_top`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. `out_data` is updated only on cycles whose input is valid, and it holds its value otherwise. Reset clears both.
- R2: With `cfg_yuv422`=0, `cfg_order` places the input components (R=`in_pix[23:16]`, G=`[15:8]`, B=`[7:0]`) on lanes 2/1/0 as follows: 0 RGB, 1 GBR, 2 BRG, 3 RBG, 4 GRB, 5 BGR. Codes 6 and 7 behave as RGB.
- R3: With `cfg_yuv422`=0, `cfg_rb_swap` has no effect on the output.
- R4: With `cfg_yuv422`=1, `cfg_order` is ignored and the order is identity. `cfg_rb_swap`=1 then exchanges the R and B positions before every other step.
- R5: `out_csc` is the registered value of `cfg_csc_en OR cfg_yuv422`, and it is 0 after reset.
- R6: Each 8-bit component is shifted left by 4 into 12 bits, then clamped. A value below the bottom limit becomes the bottom limit, and a value above the top limit becomes the top limit. If bottom exceeds top, the top limit wins. For example, limits 0x010/0xFE0 turn 0x00 into 0x010 and 0xFF into 0xFE0.
- R7: With `cfg_ycmap` in RGB layout, all three components use the luma limits.
- R8: In the Y/C layouts, Y is `in_pix[15:8]`, Cb is `[7:0]` and Cr is `[23:16]` after the R4 swap step. Y is clamped to the luma limits and Cb and Cr to the chroma limits.
- R9: `cfg_ycmap` selects the lane layout (lane2, lane1, lane0): 0 RGB = (c2,c1,c0 as ordered); 1 CYCY = (0, C, Y); 2 YCYC = (0, Y, C); 3 CY = (Cr, Cb, Y); 4 YC = (Y, Cb, Cr). Codes 5 to 7 behave as 0.
- R10: In CYCY and YCYC, C is Cb on even pixels and Cr on odd pixels. Only valid pixels are counted. The count restarts at even on the first valid pixel at or after each rising edge of `in_de`.
- R11: `cfg_depth` scales each 12-bit lane value c into a 16-bit lane: 0 gives c>>4 (8 bits), 1 gives c>>2 (10 bits), 2 gives c (12 bits), 3 gives c<<4 (16 bits). Codes 4 to 7 behave as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_de | input | 1 | Line data-enable; its rising edge restarts chroma alternation |
| in_pix | input | 24 | Input pixel, components [23:16], [15:8], [7:0] |
| cfg_rb_swap | input | 1 | Swap first and last components (4:2:2 only) |
| cfg_order | input | 3 | Channel order code |
| cfg_ycmap | input | 3 | Lane layout code |
| cfg_depth | input | 3 | Output bit-depth code |
| cfg_yuv422 | input | 1 | 4:2:2 output selected |
| cfg_csc_en | input | 1 | Conversion-active request |
| luma_bot | input | 12 | Luma / RGB bottom limit |
| luma_top | input | 12 | Luma / RGB top limit |
| chroma_bot | input | 12 | Chroma bottom limit |
| chroma_top | input | 12 | Chroma top limit |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | 48 | Lanes 2/1/0 at [47:32], [31:16], [15:0] |
| out_csc | output | 1 | Conversion-active flag |

## Verification
The chroma alternation counter and the line restart can act on the same cycle. This happens when a rising edge of `in_de` arrives together with a valid pixel while the count stands at odd. The bench forces that case after an odd number of pixels in CYCY mode and expects Cb, not Cr, on the chroma lane. It also makes a rising edge fall on an invalid cycle and expects the restart to take effect on the next valid pixel. Clamping and depth truncation also act on the same component. Crossed limits are combined with each depth code, and every result is compared against a bench model built from the tables above.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
  // channel order codes (decode only; unlisted codes fall back to identity)
  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_GBR = 3'd1;
  localparam logic [2:0] ORD_BRG = 3'd2;
  localparam logic [2:0] ORD_RBG = 3'd3;
  localparam logic [2:0] ORD_GRB = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;
  // lane layout codes
  localparam logic [2:0] LAY_RGB  = 3'd0;
  localparam logic [2:0] LAY_CYCY = 3'd1;
  localparam logic [2:0] LAY_YCYC = 3'd2;
  localparam logic [2:0] LAY_CY   = 3'd3;
  localparam logic [2:0] LAY_YC   = 3'd4;
  // depth codes
  localparam logic [2:0] DEP_8  = 3'd0;
  localparam logic [2:0] DEP_10 = 3'd1;
  localparam logic [2:0] DEP_12 = 3'd2;
  localparam logic [2:0] DEP_16 = 3'd3;

  function automatic logic is_yc_layout(input logic [2:0] lay);
    return (lay == LAY_CYCY) || (lay == LAY_YCYC) || (lay == LAY_CY) || (lay == LAY_YC);
  endfunction
endpackage

// File: rtl/pfmt_swizzle.sv
module pfmt_swizzle #(
  parameter int CIN = 8
) (
  input  logic [3*CIN-1:0] pix_i,
  input  logic             rb_swap,
  input  logic [2:0]       order,
  input  logic             yuv422,
  output logic [3*CIN-1:0] pix_o
);
  import pfmt_pkg::*;

  logic [CIN-1:0] c_hi, c_mid, c_lo;
  assign c_hi  = pix_i[3*CIN-1 -: CIN];
  assign c_mid = pix_i[2*CIN-1 -: CIN];
  assign c_lo  = pix_i[CIN-1 -: CIN];

  always_comb begin
    if (yuv422) begin
      // 4:2:2: order pinned to identity, optional first/last exchange
      pix_o = rb_swap ? {c_lo, c_mid, c_hi} : {c_hi, c_mid, c_lo};
    end else begin
      case (order)
        ORD_GBR: pix_o = {c_mid, c_lo,  c_hi};
        ORD_BRG: pix_o = {c_lo,  c_hi,  c_mid};
        ORD_RBG: pix_o = {c_hi,  c_lo,  c_mid};
        ORD_GRB: pix_o = {c_mid, c_hi,  c_lo};
        ORD_BGR: pix_o = {c_lo,  c_mid, c_hi};
        default: pix_o = {c_hi,  c_mid, c_lo};
      endcase
    end
  end
endmodule

// File: rtl/pfmt_clamp.sv
module pfmt_clamp #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] lim_bot,
  input  logic [CW-1:0] lim_top,
  output logic [CW-1:0] val_o
);
  logic [CW-1:0] raised;
  // bottom applied first so the top limit wins when limits cross
  assign raised = (val_i < lim_bot) ? lim_bot : val_i;
  assign val_o  = (raised > lim_top) ? lim_top : raised;
endmodule

// File: rtl/pfmt_pack.sv
module pfmt_pack #(
  parameter int CW = 12,
  parameter int LW = 16
) (
  input  logic [CW-1:0]   k_hi,    // R or Cr
  input  logic [CW-1:0]   k_mid,   // G or Y
  input  logic [CW-1:0]   k_lo,    // B or Cb
  input  logic [2:0]      layout,
  input  logic [2:0]      depth,
  input  logic            odd_px,
  output logic [3*LW-1:0] lanes
);
  import pfmt_pkg::*;

  // requires 12 <= CW <= 16 <= LW
  function automatic logic [LW-1:0] scale(input logic [CW-1:0] c, input logic [2:0] d);
    logic [LW-1:0] w;
    w = LW'(c);
    case (d)
      DEP_10:  return w >> (CW - 10);
      DEP_12:  return w >> (CW - 12);
      DEP_16:  return w << (16 - CW);
      default: return w >> (CW - 8);
    endcase
  endfunction

  logic [CW-1:0] chroma;
  logic [CW-1:0] l2, l1, l0;
  logic          l2_zero;

  assign chroma = odd_px ? k_hi : k_lo;

  always_comb begin
    l2_zero = 1'b0;
    case (layout)
      LAY_CYCY: begin l2 = '0;   l1 = chroma; l0 = k_mid;  l2_zero = 1'b1; end
      LAY_YCYC: begin l2 = '0;   l1 = k_mid;  l0 = chroma; l2_zero = 1'b1; end
      LAY_CY:   begin l2 = k_hi;  l1 = k_lo;  l0 = k_mid;  end
      LAY_YC:   begin l2 = k_mid; l1 = k_lo;  l0 = k_hi;   end
      default:  begin l2 = k_hi;  l1 = k_mid; l0 = k_lo;   end
    endcase
  end

  assign lanes = {(l2_zero ? '0 : scale(l2, depth)), scale(l1, depth), scale(l0, depth)};
endmodule

// File: rtl/pfmt_top.sv
module pfmt_top #(
  parameter int CIN = 8,
  parameter int CW  = 12,
  parameter int LW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_de,
  input  logic [3*CIN-1:0]  in_pix,
  input  logic              cfg_rb_swap,
  input  logic [2:0]        cfg_order,
  input  logic [2:0]        cfg_ycmap,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_yuv422,
  input  logic              cfg_csc_en,
  input  logic [CW-1:0]     luma_bot,
  input  logic [CW-1:0]     luma_top,
  input  logic [CW-1:0]     chroma_bot,
  input  logic [CW-1:0]     chroma_top,
  output logic              out_valid,
  output logic [3*LW-1:0]   out_data,
  output logic              out_csc
);
  import pfmt_pkg::*;

  localparam int PW = 3 * CIN;
  localparam int OW = 3 * LW;
  localparam int SH = CW - CIN;

  // ---------------- channel order ----------------
  logic [PW-1:0] swz;
  pfmt_swizzle #(.CIN(CIN)) u_swz (
    .pix_i  (in_pix),
    .rb_swap(cfg_rb_swap),
    .order  (cfg_order),
    .yuv422 (cfg_yuv422),
    .pix_o  (swz)
  );

  // ---------------- widen and clamp ----------------
  logic          yc_mode;
  logic [CW-1:0] clamped [3];
  assign yc_mode = is_yc_layout(cfg_ycmap);

  for (genvar k = 0; k < 3; k++) begin : g_comp
    localparam bit CAN_BE_CHROMA = (k != 1);
    logic [CW-1:0] wide, bot, top;
    logic          use_chroma;
    assign wide       = CW'(swz[(2-k)*CIN +: CIN]) << SH;
    assign use_chroma = CAN_BE_CHROMA && yc_mode;
    assign bot        = use_chroma ? chroma_bot : luma_bot;
    assign top        = use_chroma ? chroma_top : luma_top;
    pfmt_clamp #(.CW(CW)) u_clamp (
      .val_i  (wide),
      .lim_bot(bot),
      .lim_top(top),
      .val_o  (clamped[k])
    );
  end

  // ---------------- chroma alternation ----------------
  logic de_q, par_q, restart_q;
  logic de_d, par_d, restart_d;
  logic de_rise, phase;

  assign de_rise = in_de & ~de_q;
  assign phase   = (de_rise | restart_q) ? 1'b0 : par_q;

  always_comb begin
    de_d      = in_de;
    par_d     = par_q;
    restart_d = restart_q | de_rise;
    if (in_valid) begin
      par_d     = ~phase;
      restart_d = 1'b0;
    end
  end

  // ---------------- layout and depth ----------------
  logic [OW-1:0] packed_px;
  pfmt_pack #(.CW(CW), .LW(LW)) u_pack (
    .k_hi  (clamped[0]),
    .k_mid (clamped[1]),
    .k_lo  (clamped[2]),
    .layout(cfg_ycmap),
    .depth (cfg_depth),
    .odd_px(phase),
    .lanes (packed_px)
  );

  // ---------------- output stage ----------------
  logic [OW-1:0] data_d;
  logic          csc_d;
  assign data_d = in_valid ? packed_px : out_data;
  assign csc_d  = cfg_csc_en | cfg_yuv422;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_csc   <= 1'b0;
      de_q      <= 1'b0;
      par_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= data_d;
      out_csc   <= csc_d;
      de_q      <= de_d;
      par_q     <= par_d;
      restart_q <= restart_d;
    end
  end
endmodule

// File: rtl/pfmt_checker.sv
module pfmt_checker #(
  parameter int CW = 12,
  parameter int LW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      cfg_ycmap,
  input logic [2:0]      cfg_depth,
  input logic            cfg_yuv422,
  input logic [CW-1:0]   luma_bot,
  input logic [CW-1:0]   luma_top,
  input logic            out_valid,
  input logic [3*LW-1:0] out_data,
  input logic            out_csc
);
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  assert_csc_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_yuv422 |=> out_csc);
  assert_blank_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_ycmap == 3'd1 || cfg_ycmap == 3'd2)) |=> (out_data[3*LW-1 -: LW] == '0));

  for (genvar k = 0; k < 3; k++) begin : g_rng
    assert_clamp_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_ycmap == 3'd0 && cfg_depth == 3'd2 && luma_bot <= luma_top) |=>
      ((out_data[k*LW +: LW] >= LW'($past(luma_bot))) &&
       (out_data[k*LW +: LW] <= LW'($past(luma_top)))));
  end
endmodule

bind pfmt_top pfmt_checker #(.CW(CW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .cfg_ycmap (cfg_ycmap),
  .cfg_depth (cfg_depth),
  .cfg_yuv422(cfg_yuv422),
  .luma_bot  (luma_bot),
  .luma_top  (luma_top),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_csc   (out_csc)
);

// File: tb/tb_pfmt_top.sv
module tb_pfmt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_de;
  logic [23:0] in_pix;
  logic        cfg_rb_swap, cfg_yuv422, cfg_csc_en;
  logic [2:0]  cfg_order, cfg_ycmap, cfg_depth;
  logic [11:0] luma_bot, luma_top, chroma_bot, chroma_top;
  logic        out_valid, out_csc;
  logic [47:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pfmt_top dut (.*);

  // bench-side line parity state
  bit m_deq = 0, m_par = 0, m_restart = 0;
  logic [47:0] m_last = '0;

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] lim(input logic [11:0] v, input logic [11:0] b, input logic [11:0] t);
    logic [11:0] r;
    r = v;
    if (r < b) r = b;
    if (r > t) r = t;
    return r;
  endfunction

  function automatic logic [15:0] dep(input logic [11:0] v, input logic [2:0] d);
    case (d)
      3'd1: return {6'd0, v[11:2]};
      3'd2: return {4'd0, v};
      3'd3: return {v, 4'd0};
      default: return {8'd0, v[11:4]};
    endcase
  endfunction

  function automatic logic [47:0] model(input logic [23:0] p, input bit odd);
    logic [7:0]  r, g, b, a2, a1, a0;
    logic [11:0] x2, x1, x0;
    bit yc;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    if (cfg_yuv422) begin
      if (cfg_rb_swap) begin a2 = b; a1 = g; a0 = r; end
      else begin a2 = r; a1 = g; a0 = b; end
    end else begin
      case (cfg_order)
        3'd1: begin a2 = g; a1 = b; a0 = r; end
        3'd2: begin a2 = b; a1 = r; a0 = g; end
        3'd3: begin a2 = r; a1 = b; a0 = g; end
        3'd4: begin a2 = g; a1 = r; a0 = b; end
        3'd5: begin a2 = b; a1 = g; a0 = r; end
        default: begin a2 = r; a1 = g; a0 = b; end
      endcase
    end
    yc = (cfg_ycmap >= 3'd1 && cfg_ycmap <= 3'd4);
    x1 = lim({a1, 4'h0}, luma_bot, luma_top);
    x2 = yc ? lim({a2, 4'h0}, chroma_bot, chroma_top) : lim({a2, 4'h0}, luma_bot, luma_top);
    x0 = yc ? lim({a0, 4'h0}, chroma_bot, chroma_top) : lim({a0, 4'h0}, luma_bot, luma_top);
    // x2 = Cr, x1 = Y, x0 = Cb in Y/C layouts
    case (cfg_ycmap)
      3'd1: return {16'd0, dep(odd ? x2 : x0, cfg_depth), dep(x1, cfg_depth)};
      3'd2: return {16'd0, dep(x1, cfg_depth), dep(odd ? x2 : x0, cfg_depth)};
      3'd3: return {dep(x2, cfg_depth), dep(x0, cfg_depth), dep(x1, cfg_depth)};
      3'd4: return {dep(x1, cfg_depth), dep(x0, cfg_depth), dep(x2, cfg_depth)};
      default: return {dep(x2, cfg_depth), dep(x1, cfg_depth), dep(x0, cfg_depth)};
    endcase
  endfunction

  // one cycle: drive at negedge, check after the capturing edge
  task automatic step(input bit v, input bit de, input logic [23:0] p);
    bit rise, ph;
    in_valid = v; in_de = de; in_pix = p;
    rise = de && !m_deq;
    ph = (rise || m_restart) ? 1'b0 : m_par;
    if (v) begin
      m_last = model(p, ph);
      m_par = !ph;
      m_restart = 0;
    end else if (rise) m_restart = 1;
    m_deq = de;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic px(input string tag, input logic [23:0] p, input logic [47:0] exp);
    step(1, 1, p);
    chk(tag, out_data, exp);
    chk({tag, " valid"}, {47'd0, out_valid}, 48'd1);
  endtask

  task automatic cfg(input logic [2:0] o, input logic [2:0] y, input logic [2:0] d,
                     input bit yuv, input bit sw);
    cfg_order = o; cfg_ycmap = y; cfg_depth = d; cfg_yuv422 = yuv; cfg_rb_swap = sw;
  endtask

  task automatic full_range();
    luma_bot = 12'h000; luma_top = 12'hFFF; chroma_bot = 12'h000; chroma_top = 12'hFFF;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; in_de = 0; in_pix = '0; cfg_csc_en = 0;
    cfg(0, 0, 0, 0, 0); full_range();
    repeat (3) @(negedge clk);
    // R1 / R5 reset state
    chk("R1 reset valid", {47'd0, out_valid}, 48'd0);
    chk("R1 reset data", out_data, 48'd0);
    chk("R5 reset csc", {47'd0, out_csc}, 48'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 channel orders, 8-bit depth
    cfg(1, 0, 0, 0, 0); px("R2 GBR", 24'h112233, {16'h22, 16'h33, 16'h11});
    cfg(2, 0, 0, 0, 0); px("R2 BRG", 24'h112233, {16'h33, 16'h11, 16'h22});
    cfg(5, 0, 0, 0, 0); px("R2 BGR", 24'h112233, {16'h33, 16'h22, 16'h11});
    cfg(7, 0, 0, 0, 0); px("R2 code7", 24'h112233, {16'h11, 16'h22, 16'h33});
    // R3 swap ignored without 4:2:2
    cfg(0, 0, 0, 0, 1); px("R3 swap ignored", 24'h112233, {16'h11, 16'h22, 16'h33});
    // R4 4:2:2 pins order, swap active
    cfg(5, 0, 0, 1, 0); px("R4 order pinned", 24'h112233, {16'h11, 16'h22, 16'h33});
    cfg(5, 0, 0, 1, 1); px("R4 swap", 24'h112233, {16'h33, 16'h22, 16'h11});
    // R5 csc flag
    chk("R5 forced", {47'd0, out_csc}, 48'd1);
    cfg(0, 0, 0, 0, 0); step(0, 0, '0);
    chk("R5 off", {47'd0, out_csc}, 48'd0);
    cfg_csc_en = 1; step(0, 0, '0);
    chk("R5 pass", {47'd0, out_csc}, 48'd1);
    cfg_csc_en = 0;
    // R1 hold on invalid cycle
    px("R1 load", 24'h0A0B0C, {16'h0A, 16'h0B, 16'h0C});
    step(0, 1, 24'hFFFFFF);
    chk("R1 hold", out_data, {16'h0A, 16'h0B, 16'h0C});
    chk("R1 drop", {47'd0, out_valid}, 48'd0);
    // R6 limited range clamp, 12-bit depth
    luma_bot = 12'h010; luma_top = 12'hFE0;
    cfg(0, 0, 2, 0, 0); px("R6 limited", 24'h00FF80, {16'h010, 16'hFE0, 16'h800});
    luma_bot = 12'h800; luma_top = 12'h100;
    px("R6 crossed", 24'h00FF80, {16'h100, 16'h100, 16'h100});
    // R7 RGB uses luma limits only
    luma_bot = 12'h100; luma_top = 12'h200; chroma_bot = 12'h000; chroma_top = 12'hFFF;
    px("R7 rgb luma", 24'h05FF80, {16'h100, 16'h200, 16'h200});
    // R8 Y/C roles
    chroma_bot = 12'h300; chroma_top = 12'h400;
    cfg(0, 3, 2, 0, 0); px("R8 CY", 24'h05FF80, {16'h300, 16'h400, 16'h200});
    cfg(0, 4, 2, 0, 0); px("R8 YC", 24'h05FF80, {16'h200, 16'h400, 16'h300});
    // R9 unknown layout codes
    full_range();
    cfg(0, 6, 0, 0, 0); px("R9 code6", 24'h112233, {16'h11, 16'h22, 16'h33});
    // R11 depths
    cfg(0, 0, 1, 0, 0); px("R11 10bit", 24'hAB1234, {16'h2AC, 16'h048, 16'h0D0});
    cfg(0, 0, 3, 0, 0); px("R11 16bit", 24'hAB1234, {16'hAB00, 16'h1200, 16'h3400});
    cfg(0, 0, 7, 0, 0); px("R11 code7", 24'hAB1234, {16'hAB, 16'h12, 16'h34});
    // R10 alternation: line start, three pixels, DE drop
    cfg(0, 1, 0, 0, 0);
    step(0, 0, '0);
    px("R10 even", 24'h112233, {16'h0, 16'h33, 16'h22});
    px("R10 odd", 24'h112233, {16'h0, 16'h11, 16'h22});
    px("R10 even2", 24'h112233, {16'h0, 16'h33, 16'h22});
    step(0, 0, '0);
    // rise coincides with a valid pixel while parity is odd
    px("R10 restart", 24'h112233, {16'h0, 16'h33, 16'h22});
    step(0, 0, '0);
    step(0, 1, '0);  // rise on an invalid cycle
    step(0, 1, '0);
    cfg(0, 2, 0, 0, 0);
    px("R10 deferred", 24'h112233, {16'h0, 16'h22, 16'h33});
    px("R10 YCYC odd", 24'h112233, {16'h0, 16'h22, 16'h11});

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [23:0] p;
      bit v, de;
      p = 24'($urandom);
      v = ($urandom % 4) != 0;
      de = ($urandom % 8) != 0;
      if (i % 50 == 0) begin
        cfg(3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
        luma_bot = 12'($urandom % 12'h200); luma_top = 12'hFFF - 12'($urandom % 12'h200);
        chroma_bot = 12'($urandom); chroma_top = 12'($urandom);
      end
      step(v, de, p);
      chk(cfg_ycmap inside {3'd1, 3'd2} ? "R10 random" : "R9 random", out_data, m_last);
      chk("R1 random valid", {47'd0, out_valid}, {47'd0, v});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule